// File: doc/BRIEF.md
# Field-Partitioned Microcode Sequencer

This block drives the activation signals of a scheduled datapath from a small control store. The signals are split into groups, and within one group at most one signal is active in any schedule step. Each group owns a narrow field of the control word and names its active signal by code rather than by a wire per signal. A step counter walks the store one word per clock. Every field goes to its own small decoder, and the decoder outputs are joined into the full activation vector. Groups therefore stay fully concurrent, while the word is narrower than one bit per signal.

The field layout is fixed at compile time by three parameter tables: the width of each field, the number of signals it drives, and whether it is coded one-hot or binary. Field 0 occupies the least significant bits of the word and drives the least significant activation signals. The store is a plain synchronous RAM that the surrounding logic fills through a write port before the schedule runs. The counter wraps after the last step, so the schedule repeats.

Top module: `mcf_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `step_o` becomes 0 and `act_o` and `err_o` become 0.
- R2: With `run` high, each clock edge raises `step_o` by one, and it goes from STEPS-1 back to 0.
- R3: With `run` low, `step_o` keeps its value, and after one edge `act_o` and `err_o` also hold steady as long as the store is not written.
- R4: The `act_o`/`err_o` value present after an edge is the decode of the store word at the address `step_o` showed before that edge, which is one cycle behind the counter.
- R5: With the default layout, the word fields map as follows: bits [2:0] are one-hot and drive `act_o[2:0]`; bits [4:3] are binary and drive `act_o[5:3]`; bits [6:5] are binary and drive `act_o[7:6]`; bit [7] is one-hot and drives `act_o[8]`; bits [10:8] are binary and drive `act_o[10:9]`.
- R6: A binary field holding code c, with 1 <= c <= its signal count, activates only signal c-1 of its group.
- R7: A field that is all zero drives no signal of its group.
- R8: A binary code above the group's signal count drives no signal and raises no error.
- R9: A one-hot field with more than one bit set drives no signal of its group and sets `err_o`, with the same timing as `act_o`.
- R10: A single word drives all groups in the same step, and the groups decode independently of one another.
- R11: When `ld_en` is high at a clock edge, `ld_word` is written into the store at `ld_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Advance the step counter |
| ld_en | input | 1 | Store write enable |
| ld_addr | input | AW | Store write address |
| ld_word | input | WORD_W | Control word to write |
| step_o | output | AW | Current schedule step |
| act_o | output | ACT_W | Registered activation vector |
| err_o | output | 1 | Registered flag for a malformed one-hot field |

## Verification
The assertions assume that every store address the counter reaches has been written before reset is released. They also assume that the store is not written at an address while that same address is being read, since the hold check on the outputs is only made when no write has happened in the two cycles before it. The bench fills the whole store while reset is high and keeps `ld_en` low whenever the counter runs or pauses. It sweeps every legal code combination of the five groups through a 13-step schedule, and then runs a batch of malformed one-hot codes and out-of-range binary codes with a pause in the middle.

// File: rtl/mcf_pkg.sv
package mcf_pkg;

  // Layout tables hold one byte per field, field 0 in the low byte.
  localparam int unsigned MAX_FIELDS = 16;
  localparam int unsigned TAB_W      = MAX_FIELDS * 8;

  function automatic int unsigned tab_at(input logic [TAB_W-1:0] tab,
                                         input int unsigned idx);
    return int'(tab[idx*8 +: 8]);
  endfunction

  function automatic int unsigned tab_sum(input logic [TAB_W-1:0] tab,
                                          input int unsigned n);
    int unsigned acc;
    acc = 0;
    for (int unsigned i = 0; i < n; i++) begin
      acc += int'(tab[i*8 +: 8]);
    end
    return acc;
  endfunction

endpackage

// File: rtl/mcf_step_counter.sv
module mcf_step_counter #(
  parameter int unsigned STEPS = 16,
  parameter int unsigned AW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  output logic [AW-1:0] step_q,
  output logic [AW-1:0] step_nxt
);

  localparam logic [AW-1:0] LAST = AW'(STEPS - 1);

  always_comb begin
    if (rst) begin
      step_nxt = '0;
    end else if (run) begin
      step_nxt = (step_q == LAST) ? '0 : step_q + 1'b1;
    end else begin
      step_nxt = step_q;
    end
  end

  always_ff @(posedge clk) begin
    step_q <= step_nxt;
  end

  a_r2_advance: assert property (@(posedge clk) disable iff (rst)
    (run && step_q != LAST) |=> (step_q == $past(step_q) + 1'b1));

  a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
    (run && step_q == LAST) |=> (step_q == '0));

  a_r3_hold_step: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(step_q));

  a_r2_in_range: assert property (@(posedge clk) disable iff (rst)
    step_q <= LAST);

endmodule

// File: rtl/mcf_store.sv
module mcf_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = 4,
  parameter int unsigned DW    = 11
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] mem [DEPTH];

  // Single clocked process with a registered read, so a RAM block fits.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/mcf_field_dec.sv
module mcf_field_dec #(
  parameter int unsigned W      = 3,
  parameter int unsigned N      = 3,
  parameter bit          ONEHOT = 1'b0
) (
  input  logic [W-1:0] code,
  output logic [N-1:0] sig,
  output logic         bad
);

  generate
    if (ONEHOT) begin : g_onehot
      logic multi;
      assign multi = (code & (code - 1'b1)) != '0;
      assign bad   = multi;
      assign sig   = multi ? '0 : N'(code);
    end else begin : g_binary
      assign bad = 1'b0;
      for (genvar j = 0; j < N; j++) begin : g_sig
        assign sig[j] = (code == W'(j + 1));
      end
    end
  endgenerate

endmodule

// File: rtl/mcf_ctrl.sv
module mcf_ctrl #(
  parameter int unsigned STEPS = 16,
  parameter int unsigned NF    = 5,
  parameter logic [NF*8-1:0] F_WIDTH = {8'd3, 8'd1, 8'd2, 8'd2, 8'd3},
  parameter logic [NF*8-1:0] F_COUNT = {8'd2, 8'd1, 8'd2, 8'd3, 8'd3},
  parameter logic [NF-1:0]   F_OH    = 5'b01001,
  localparam int unsigned TW     = mcf_pkg::TAB_W,
  localparam logic [TW-1:0] WTAB = TW'(F_WIDTH),
  localparam logic [TW-1:0] NTAB = TW'(F_COUNT),
  localparam int unsigned AW     = (STEPS > 1) ? $clog2(STEPS) : 1,
  localparam int unsigned WORD_W = mcf_pkg::tab_sum(WTAB, NF),
  localparam int unsigned ACT_W  = mcf_pkg::tab_sum(NTAB, NF)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              ld_en,
  input  logic [AW-1:0]     ld_addr,
  input  logic [WORD_W-1:0] ld_word,
  output logic [AW-1:0]     step_o,
  output logic [ACT_W-1:0]  act_o,
  output logic              err_o
);

  logic [AW-1:0]     step_q;
  logic [AW-1:0]     step_nxt;
  logic [WORD_W-1:0] word_q;
  logic [ACT_W-1:0]  act_d;
  logic [NF-1:0]     bad_d;

  mcf_step_counter #(.STEPS(STEPS), .AW(AW)) i_cnt (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .step_q   (step_q),
    .step_nxt (step_nxt)
  );

  // Reading at the next address keeps word_q aligned with step_q.
  mcf_store #(.DEPTH(STEPS), .AW(AW), .DW(WORD_W)) i_store (
    .clk     (clk),
    .wr_en   (ld_en),
    .wr_addr (ld_addr),
    .wr_data (ld_word),
    .rd_addr (step_nxt),
    .rd_data (word_q)
  );

  generate
    for (genvar f = 0; f < NF; f++) begin : g_field
      localparam int unsigned FW   = mcf_pkg::tab_at(WTAB, f);
      localparam int unsigned FN   = mcf_pkg::tab_at(NTAB, f);
      localparam int unsigned WOFF = mcf_pkg::tab_sum(WTAB, f);
      localparam int unsigned AOFF = mcf_pkg::tab_sum(NTAB, f);

      mcf_field_dec #(.W(FW), .N(FN), .ONEHOT(F_OH[f])) i_dec (
        .code (word_q[WOFF +: FW]),
        .sig  (act_d[AOFF +: FN]),
        .bad  (bad_d[f])
      );

      a_r6_group_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0(act_o[AOFF +: FN]));

      a_r7_idle_code: assert property (@(posedge clk) disable iff (rst)
        (word_q[WOFF +: FW] == '0) |=> (act_o[AOFF +: FN] == '0));

      if (F_OH[f]) begin : g_oh_chk
        a_r9_multi_hot: assert property (@(posedge clk) disable iff (rst)
          ($countones(word_q[WOFF +: FW]) > 1) |=>
            (err_o && act_o[AOFF +: FN] == '0));
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      act_o <= '0;
      err_o <= 1'b0;
    end else begin
      act_o <= act_d;
      err_o <= |bad_d;
    end
  end

  assign step_o = step_q;

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (step_o == '0 && act_o == '0 && !err_o));

  a_r3_hold_outputs: assert property (@(posedge clk) disable iff (rst)
    (!run && $past(!run) && !ld_en && $past(!ld_en)) |=>
      ($stable(act_o) && $stable(err_o)));

endmodule

// File: tb/test_mcf_ctrl.sv
module test_mcf_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int S          = 13;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic        ld_en = 1'b0;
  logic [3:0]  ld_addr = '0;
  logic [10:0] ld_word = '0;
  logic [3:0]  step_o;
  logic [10:0] act_o;
  logic        err_o;

  int checks = 0;
  int errors = 0;

  logic [10:0] wd   [S];
  logic [10:0] ract [S];
  logic        rerr [S];

  always #(CLK_PERIOD/2) clk = ~clk;

  mcf_ctrl #(.STEPS(S)) i_mcf_ctrl (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .ld_en   (ld_en),
    .ld_addr (ld_addr),
    .ld_word (ld_word),
    .step_o  (step_o),
    .act_o   (act_o),
    .err_o   (err_o)
  );

  task automatic chk(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
    end
  endtask

  // Encode one step from raw field codes and derive the horizontal reference.
  task automatic build(input int s, input int f0, input int f1, input int f2,
                       input int f3, input int f4);
    logic [10:0] a;
    logic e;
    int ones;
    a = '0;
    e = 1'b0;
    ones = (f0 & 1) + ((f0 >> 1) & 1) + ((f0 >> 2) & 1);
    if (ones > 1) e = 1'b1;
    else a[2:0] = 3'(f0);
    if (f1 >= 1 && f1 <= 3) a[3 + f1 - 1] = 1'b1;
    if (f2 >= 1 && f2 <= 2) a[6 + f2 - 1] = 1'b1;
    if (f3 == 1) a[8] = 1'b1;
    if (f4 >= 1 && f4 <= 2) a[9 + f4 - 1] = 1'b1;
    wd[s]   = 11'(f0 | (f1 << 3) | (f2 << 5) | (f3 << 7) | (f4 << 8));
    ract[s] = a;
    rerr[s] = e;
  endtask

  task automatic run_batch(input bit with_pause, input string tags);
    int st;
    int rd;
    int ai;
    int ns;
    rst = 1'b1;
    run = 1'b0;
    for (int s = 0; s < S; s++) begin
      ld_en = 1'b1;
      ld_addr = 4'(s);
      ld_word = wd[s];
      @(negedge clk);
    end
    ld_en = 1'b0;
    @(negedge clk);
    chk(step_o == 4'd0 && act_o == '0 && err_o == 1'b0, "R1 reset state",
        {step_o, act_o, err_o}, 0);
    rst = 1'b0;
    st = 0;
    rd = 0;
    for (int c = 0; c < 34; c++) begin
      run = !(with_pause && c >= 7 && c < 11);
      @(negedge clk);
      ai = rd;
      ns = run ? ((st == S - 1) ? 0 : st + 1) : st;
      rd = ns;
      st = ns;
      if (run) chk(step_o == 4'(st), "R2 step advance/wrap", step_o, st);
      else     chk(step_o == 4'(st), "R3 step held while paused", step_o, st);
      chk(act_o == ract[ai], tags, act_o, ract[ai]);
      chk(err_o == rerr[ai], "R4 R9 error flag", err_o, rerr[ai]);
    end
    run = 1'b0;
  endtask

  initial begin
    int combo;
    @(negedge clk);
    // Sweep all 4*4*3*2*3 legal combinations, 13 per batch.
    for (int b = 0; b < 23; b++) begin
      for (int s = 0; s < S; s++) begin
        int g0, g1, g2, g3, g4;
        combo = (b * S + s) % 288;
        g0 = combo % 4;
        g1 = (combo / 4) % 4;
        g2 = (combo / 16) % 3;
        g3 = (combo / 48) % 2;
        g4 = (combo / 96) % 3;
        build(s, (g0 == 0) ? 0 : (1 << (g0 - 1)), g1, g2, g3, g4);
      end
      run_batch(b == 0, "R4 R5 R6 R7 R10 R11 activation");
    end
    // Malformed one-hot codes and out-of-range binary codes.
    for (int s = 0; s < S; s++) begin
      build(s, s % 8, s % 4, (s % 2 == 0) ? 3 : s % 3, s & 1, (s + 3) % 8);
    end
    run_batch(1'b1, "R3 R8 R9 bad codes");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule